// File: doc/BRIEF.md
# Palette RAM Load Sequencer

This block fills a 256-entry by 16-bit colour palette from a stream of 32-bit words. The words come from the first DMA channel. The pixel depth sets how many entries a load covers. At 1 and 2 bits per pixel the load covers 4 entries, of which 1 bpp uses only the first two. At 4 bits per pixel it covers 16 entries, and at 8 bits it covers all 256. At 16 bits per pixel the palette is bypassed and nothing is loaded. Each word carries two entries, which are written one per cycle with the lower entry taken from the lower half-word.

When the block is enabled, it withholds permission to process frame data until the first load has ended. If the reload flag is set, every frame start triggers a fresh load before that frame's pixels are allowed through. While a load runs, the channel is reserved for palette words. At all other times the sequencer refuses words. A registered read port turns a pixel index into its stored colour.

Top module: `pal_load_seq`

## Requirements
- R1: After reset, `frame_ok_o`, `word_ready_o`, `pal_we_o` and `load_done_o` are all low.
- R2: With `en_i` raised and `bpp_i` = 0 (1 bpp) or 1 (2 bpp), exactly 4 entries (two words) are written, after which the load ends.
- R3: With `bpp_i` = 2 (4 bpp), 16 entries are written. With `bpp_i` = 3 (8 bpp), all 256 entries are written.
- R4: With `bpp_i` = 4 (16 bpp), or with the unused codes 5 to 7, no load takes place. `frame_ok_o` rises the cycle after `en_i` rises, and `word_ready_o` stays low, with no write and no `load_done_o` pulse.
- R5: Word n is written to entry 2n from bits [15:0] and then to entry 2n+1 from bits [31:16], on consecutive cycles. Addresses ascend from 0.
- R6: `frame_ok_o` stays low from enable until the load ends, and rises in the cycle in which `load_done_o` is high.
- R7: `load_done_o` is a single-cycle pulse in the cycle after the final entry write.
- R8: `word_ready_o` is high only while the load still needs words. A word offered while it is low produces no write and leaves the palette unchanged.
- R9: When `frame_start_i` and `reload_i` are both high while frame data is allowed, `frame_ok_o` drops the next cycle and a full load restarts at entry 0. A frame start with `reload_i` low has no effect.
- R10: `pix_color_o` shows the entry addressed by `pix_idx_i` one cycle later.
- R11: When `en_i` is lowered, `frame_ok_o` and `word_ready_o` are low by the next cycle. A later enable starts a fresh load at entry 0, even if the earlier load was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| bpp_i | input | 3 | Pixel depth code: 0=1, 1=2, 2=4, 3=8, 4=16 bpp |
| reload_i | input | 1 | Reload palette at every frame start |
| frame_start_i | input | 1 | Start-of-frame strobe |
| word_valid_i | input | 1 | Palette word offered on the channel |
| word_i | input | 32 | Palette word, two entries |
| word_ready_o | output | 1 | Word accepted this cycle if valid |
| pal_we_o | output | 1 | Palette write strobe |
| pal_waddr_o | output | 8 | Palette write address |
| pal_wdata_o | output | 16 | Palette write data |
| load_done_o | output | 1 | Load-finished pulse |
| frame_ok_o | output | 1 | Frame data may be processed |
| pix_idx_i | input | 8 | Pixel index to look up |
| pix_color_o | output | 16 | Colour for the index, one cycle later |

## Verification
A stale entry counter shows up at once on `pal_waddr_o`: either the first write of a load does not land at 0, or a load ends with the wrong number of writes. The bench checks both the count and the address of every write. A half-word selection or ordering fault swaps the data written at even and odd addresses, which the write log shows on the first word. A wrong sequencer state shows within one cycle, as `frame_ok_o` rising before the load ends or `word_ready_o` staying high after it.

// File: rtl/pal_seq_pkg.sv
package pal_seq_pkg;
  typedef enum logic [2:0] {
    BPP_1  = 3'd0,
    BPP_2  = 3'd1,
    BPP_4  = 3'd2,
    BPP_8  = 3'd3,
    BPP_16 = 3'd4
  } bpp_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_LOAD,
    ST_RUN
  } seq_st_e;
endpackage

// File: rtl/pal_len_dec.sv
module pal_len_dec
  import pal_seq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic [2:0]    bpp_i,
  output logic [CW-1:0] len_o
);
  always_comb begin
    unique case (bpp_e'(bpp_i))
      BPP_1, BPP_2: len_o = CW'(4);
      BPP_4:        len_o = CW'(16);
      BPP_8:        len_o = CW'(DEPTH);
      default:      len_o = '0;  // 16 bpp and unused codes: bypass
    endcase
  end
endmodule

// File: rtl/pal_unpack.sv
module pal_unpack #(
  parameter int DEPTH   = 256,
  parameter int ENTRY_W = 16,
  parameter int WORD_W  = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               active_i,
  input  logic [CW-1:0]      len_i,
  input  logic               valid_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               ready_o,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output logic [ENTRY_W-1:0] wdata_o,
  output logic               last_o
);
  localparam int PER = WORD_W / ENTRY_W;
  localparam int PW  = $clog2(PER + 1);

  logic [WORD_W-1:0] buf_q;
  logic [PW-1:0]     left_q;
  logic [CW-1:0]     idx_q;

  assign we_o    = active_i && (left_q != '0);
  assign ready_o = active_i && (left_q == '0) && (idx_q < len_i);
  assign waddr_o = idx_q[AW-1:0];
  assign wdata_o = buf_q[ENTRY_W-1:0];  // lowest half first: little-endian entry order
  assign last_o  = we_o && (idx_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      left_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      left_q <= '0;
      idx_q  <= '0;
    end else if (we_o) begin
      buf_q  <= buf_q >> ENTRY_W;
      left_q <= left_q - PW'(1);
      idx_q  <= idx_q + CW'(1);
    end else if (ready_o && valid_i) begin
      buf_q  <= word_i;
      left_q <= PW'(PER);
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (idx_q < len_i)) else $error("write beyond load length");  // R3
  AST_ADDR_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o) && !$past(clr_i)) |-> (waddr_o == $past(waddr_o) + AW'(1)))
    else $error("write address not ascending");  // R5
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int DEPTH   = 256,
  parameter int ENTRY_W = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [ENTRY_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/pal_load_seq.sv
module pal_load_seq
  import pal_seq_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int ENTRY_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [2:0]               bpp_i,
  input  logic                     reload_i,
  input  logic                     frame_start_i,
  input  logic                     word_valid_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic                     word_ready_o,
  output logic                     pal_we_o,
  output logic [$clog2(DEPTH)-1:0] pal_waddr_o,
  output logic [ENTRY_W-1:0]       pal_wdata_o,
  output logic                     load_done_o,
  output logic                     frame_ok_o,
  input  logic [$clog2(DEPTH)-1:0] pix_idx_i,
  output logic [ENTRY_W-1:0]       pix_color_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  seq_st_e       st_q;
  logic [CW-1:0] cfg_len, len_q;
  logic          done_q, start_load, clr, last;

  pal_len_dec #(.DEPTH(DEPTH), .CW(CW)) u_len (
    .bpp_i (bpp_i),
    .len_o (cfg_len)
  );

  // load starts on enable, or on a reloading frame start; never at 16 bpp
  assign start_load = en_i && (cfg_len != '0) &&
                      ((st_q == ST_OFF) || ((st_q == ST_RUN) && frame_start_i && reload_i));
  assign clr = start_load || !en_i;

  pal_unpack #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W)) u_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .active_i (st_q == ST_LOAD),
    .len_i    (len_q),
    .valid_i  (word_valid_i),
    .word_i   (word_i),
    .ready_o  (word_ready_o),
    .we_o     (pal_we_o),
    .waddr_o  (pal_waddr_o),
    .wdata_o  (pal_wdata_o),
    .last_o   (last)
  );

  pal_ram #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we_o),
    .waddr_i (pal_waddr_o),
    .wdata_i (pal_wdata_o),
    .raddr_i (pix_idx_i),
    .rdata_o (pix_color_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= ST_OFF;
      end else begin
        unique case (st_q)
          ST_OFF: begin
            if (start_load) begin
              st_q  <= ST_LOAD;
              len_q <= cfg_len;
            end else begin
              st_q <= ST_RUN;
            end
          end
          ST_LOAD: begin
            if (last) begin
              st_q   <= ST_RUN;
              done_q <= 1'b1;
            end
          end
          ST_RUN: begin
            if (start_load) begin
              st_q  <= ST_LOAD;
              len_q <= cfg_len;
            end
          end
          default: st_q <= ST_OFF;
        endcase
      end
    end
  end

  assign load_done_o = done_q;
  assign frame_ok_o  = (st_q == ST_RUN);

  AST_WRITE_GATES_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_o |-> !frame_ok_o) else $error("frame data allowed during load");  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> !load_done_o) else $error("done pulse too long");  // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_done_o) |-> $past(pal_we_o)) else $error("done without final write");  // R7
  AST_CHANNEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> !word_ready_o) else $error("palette words taken outside load");  // R8
endmodule

// File: tb/pal_load_seq_bench.sv
module pal_load_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, reload = 1'b0, frame_start = 1'b0, word_valid = 1'b0;
  logic [2:0]  bpp = 3'd0;
  logic [31:0] word = '0;
  logic [7:0]  pix_idx = '0;
  logic        word_ready, pal_we, load_done, frame_ok;
  logic [7:0]  pal_waddr;
  logic [15:0] pal_wdata, pix_color;

  int checks = 0, errors = 0, nw = 0, ndone = 0;
  logic [7:0]  log_a [512];
  logic [15:0] log_d [512];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pal_load_seq u_pal_load_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bpp_i(bpp), .reload_i(reload),
    .frame_start_i(frame_start), .word_valid_i(word_valid), .word_i(word),
    .word_ready_o(word_ready), .pal_we_o(pal_we), .pal_waddr_o(pal_waddr),
    .pal_wdata_o(pal_wdata), .load_done_o(load_done), .frame_ok_o(frame_ok),
    .pix_idx_i(pix_idx), .pix_color_o(pix_color)
  );

  always @(negedge clk) begin
    if (rst_n && pal_we && nw < 512) begin
      log_a[nw] = pal_waddr;
      log_d[nw] = pal_wdata;
      nw++;
    end
    if (rst_n && load_done) ndone++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed(int n, int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_valid = 1'b1;
      word = {16'(seed + 2*i + 1), 16'(seed + 2*i)};
      while (!word_ready) @(negedge clk);
      @(negedge clk);
    end
    word_valid = 1'b0;
  endtask

  // called at the negedge after the last word was accepted
  task automatic finish_load(int total, int seed, string req);
    int bad = 0;
    chk("R6 frame gated during load", 32'(frame_ok), 0);
    @(negedge clk);
    chk("R7 no done on final write", 32'(load_done), 0);
    @(negedge clk);
    chk("R7 done after final write", 32'(load_done), 1);
    chk("R6 frame allowed at done", 32'(frame_ok), 1);
    @(negedge clk);
    chk("R7 done single cycle", 32'(load_done), 0);
    chk(req, nw, total);
    for (int k = 0; k < total && k < nw; k++)
      if (32'(log_a[k]) != k || log_d[k] != 16'(seed + k)) bad++;
    chk("R5 entry order and data", bad, 0);
  endtask

  task automatic t_load(int code, int total, int seed, string req);
    @(negedge clk);
    bpp = 3'(code); en = 1'b1; nw = 0;
    @(negedge clk);
    chk("R6 frame gated after enable", 32'(frame_ok), 0);
    chk("R8 ready during load", 32'(word_ready), 1);
    feed(total / 2, seed);
    finish_load(total, seed, req);
  endtask

  task automatic t_off();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R11 frame_ok low after disable", 32'(frame_ok), 0);
    chk("R11 ready low after disable", 32'(word_ready), 0);
  endtask

  task automatic t_read(int idx, int exp, string req);
    @(negedge clk);
    pix_idx = 8'(idx);
    @(negedge clk);
    chk(req, 32'(pix_color), exp);
  endtask

  task automatic t_bypass(int code);
    int d0;
    @(negedge clk);
    bpp = 3'(code); en = 1'b1; nw = 0; d0 = ndone;
    @(negedge clk);
    chk("R4 frame_ok at once", 32'(frame_ok), 1);
    chk("R4 no ready", 32'(word_ready), 0);
    repeat (3) @(negedge clk);
    chk("R4 no writes", nw, 0);
    chk("R4 no done pulse", ndone - d0, 0);
    t_off();
  endtask

  task automatic t_ignore();
    @(negedge clk);
    word_valid = 1'b1; word = 32'hdead_beef; nw = 0;
    repeat (4) begin
      @(negedge clk);
      chk("R8 ready low outside load", 32'(word_ready), 0);
    end
    word_valid = 1'b0;
    chk("R8 ignored words not written", nw, 0);
    t_read(5, 'h1005, "R8 palette unchanged");
  endtask

  task automatic t_reload();
    @(negedge clk);
    reload = 1'b0; frame_start = 1'b1; nw = 0;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R9 no reload when flag clear", 32'(frame_ok), 1);
    chk("R9 no ready when flag clear", 32'(word_ready), 0);
    @(negedge clk);
    reload = 1'b1; frame_start = 1'b1; nw = 0;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R9 frame gated on reload", 32'(frame_ok), 0);
    chk("R9 ready on reload", 32'(word_ready), 1);
    feed(8, 'h500);
    finish_load(16, 'h500, "R9 reload count");
    reload = 1'b0;
    t_read(0, 'h500, "R9 reloaded entry 0");
    t_read(15, 'h50f, "R9 reloaded entry 15");
  endtask

  task automatic t_restart();
    @(negedge clk);
    bpp = 3'd1; en = 1'b1;
    @(negedge clk);
    feed(1, 'h600);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1; nw = 0;
    @(negedge clk);
    chk("R11 ready after re-enable", 32'(word_ready), 1);
    feed(2, 'h700);
    finish_load(4, 'h700, "R11 restart count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 frame_ok reset", 32'(frame_ok), 0);
    chk("R1 ready reset", 32'(word_ready), 0);
    chk("R1 we reset", 32'(pal_we), 0);
    chk("R1 done reset", 32'(load_done), 0);
    t_load(0, 4, 'h100, "R2 1bpp count");
    t_off();
    t_load(1, 4, 'h200, "R2 2bpp count");
    t_off();
    t_load(2, 16, 'h300, "R3 4bpp count");
    t_off();
    t_load(3, 256, 'h1000, "R3 8bpp count");
    t_read(0, 'h1000, "R10 read entry 0");
    t_read(1, 'h1001, "R10 read entry 1");
    t_read(128, 'h1080, "R10 read entry 128");
    t_read(255, 'h10ff, "R10 read entry 255");
    t_ignore();
    t_off();
    t_bypass(4);
    t_bypass(7);
    t_load(2, 16, 'h400, "R3 4bpp count before reload");
    t_reload();
    t_off();
    t_restart();
    t_off();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule